// File: doc/BRIEF.md
# Master-Clock Frequency Error PI Controller

This block closes the loop of a software-style clock recovery scheme in hardware. At every check point (100 times a second, one every 10 ms of local reference time) it receives two samples of a free-running 16-bit counter of recovered master-clock edges: the value at this check point and the value at the previous one. From the advance between them it derives a frequency error against the advance expected for the selected audio rate. It then updates a 20-bit tuning word that drives a fractional-N modulator.

The error is the expected advance minus the measured advance, both taken modulo 2^16, and read as a signed 16-bit value. A clock that runs fast therefore gives a negative error and pulls the tuning word down. The errors are summed into an integral term. The new tuning word is the rate's nominal word plus the integral gain times the integral plus the proportional gain times the latest error, clamped to the unsigned 20-bit range.

The first check point after reset or after a rate change only arms the controller and applies no correction. A rate change also clears the integral and reloads the nominal word of the new rate.

Top module: `clk_err_pi_top`

## Requirements
- R1: After reset with `rate_sel`=0, `tune_word` equals 498283 and `tune_valid` is 0.
- R2: The first `cnt_valid` after reset or after a rate change gives no `tune_valid` pulse and leaves `tune_word` unchanged.
- R3: The measured advance is `cnt_now - cnt_prev` modulo 2^16, so a counter wrap between the samples gives the same result as no wrap.
- R4: The per-interval error is `(expected - advance)` modulo 2^16, read as a signed 16-bit value. An advance above the expected value lowers the tuning word.
- R5: Each accepted sample adds its error to the integral. `tune_word` becomes nominal + KI·integral + KP·error, with KI=32 and KP=0 by default.
- R6: A computed word below 0 gives 0, and one above 1048575 gives 1048575.
- R7: When `rate_sel` changes, the integral is cleared and `tune_word` takes the new rate's nominal word one cycle later. A `cnt_valid` in that same cycle is ignored.
- R8: `tune_valid` is a one-cycle pulse, one cycle after each accepted `cnt_valid`. It is never high otherwise.
- R9: For `rate_sel`=0 (44.1 kHz × 512) the expected advance is 29184 and the nominal word is 498283. For `rate_sel`=1 (48 kHz × 512) they are 49152 and 478151.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rate_sel | input | 1 | 0: 44.1 kHz family, 1: 48 kHz family |
| cnt_now | input | 16 | Master-clock edge count at this check point |
| cnt_prev | input | 16 | Master-clock edge count at the previous check point |
| cnt_valid | input | 1 | One-cycle strobe: count samples are present |
| tune_word | output | 20 | Unsigned tuning word for the modulator |
| tune_valid | output | 1 | One-cycle strobe: `tune_word` has been updated |

## Verification
The assertions assume that `cnt_valid` is a strobe whose samples may come back to back, and that `rate_sel` is held steady except at a deliberate change. A change on the same cycle as a strobe is legal, and the strobe is then ignored. The stimulus drives all inputs at the falling edge and holds them for a full cycle. It spaces strobes by random idle gaps and mostly draws advances within a few hundred counts of the expected value. Directed samples that are tens of thousands of counts off drive the word into both clamps.

// File: rtl/clk_err_pi_pkg.sv
// Package: shared widths and rate constants for the master-clock PI controller.
// Assumes a two-entry rate choice selected by a single bit.
package clk_err_pi_pkg;
    localparam int CNT_W  = 16;  // master-clock counter width
    localparam int WORD_W = 20;  // tuning word width
    localparam int INT_W  = 32;  // error and integral width

    // Rate selection values as seen on rate_sel
    typedef enum logic {
        RATE_44K1 = 1'b0,
        RATE_48K  = 1'b1
    } rate_e;

    // Per-rate constants carried as a pair
    typedef struct packed {
        logic [CNT_W-1:0]  exp_adv;
        logic [WORD_W-1:0] nominal;
    } rate_cfg_t;
endpackage

// File: rtl/clk_err_rate_table.sv
// Module: rate constant lookup.
// Maps the rate selection to the expected modulo count advance per check
// point and the nominal tuning word. Assumes both values fit their widths.
module clk_err_rate_table
    import clk_err_pi_pkg::*;
#(
    parameter int unsigned EXP_44K1 = 29184,
    parameter int unsigned NOM_44K1 = 498283,
    parameter int unsigned EXP_48K  = 49152,
    parameter int unsigned NOM_48K  = 478151
) (
    input  logic      rate_sel,
    output rate_cfg_t cfg
);
    // Pick the constant pair for the selected rate
    always_comb begin
        if (rate_e'(rate_sel) == RATE_48K) begin
            cfg.exp_adv = CNT_W'(EXP_48K);
            cfg.nominal = WORD_W'(NOM_48K);
        end else begin
            cfg.exp_adv = CNT_W'(EXP_44K1);
            cfg.nominal = WORD_W'(NOM_44K1);
        end
    end
endmodule

// File: rtl/clk_err_phase_det.sv
// Module: wrapped count-advance error detector.
// Computes the advance between two counter samples modulo 2^CW, subtracts
// it from the expected advance modulo 2^CW, and sign-extends the result.
// Assumes the true error magnitude stays below 2^(CW-1).
module clk_err_phase_det #(
    parameter int CW = 16,
    parameter int EW = 32
) (
    input  logic [CW-1:0]        cnt_now,
    input  logic [CW-1:0]        cnt_prev,
    input  logic [CW-1:0]        exp_adv,
    output logic signed [EW-1:0] err
);
    localparam int EXT_W = EW - CW;

    logic [CW-1:0] advance;
    logic [CW-1:0] diff;

    // Modulo advance, then error with a fast clock negative
    always_comb begin
        advance = cnt_now - cnt_prev;
        diff    = exp_adv - advance;
        err     = {{EXT_W{diff[CW-1]}}, diff};
    end
endmodule

// File: rtl/clk_err_pi_core.sv
// Module: integral accumulator and clamped tuning word register.
// On upd adds err to the integral and loads the clamped sum of nominal,
// KI*integral and KP*err. On clr zeroes the integral and loads nominal.
// Assumes the integral does not exceed INT_W bits over a run.
module clk_err_pi_core #(
    parameter int IW = 32,
    parameter int TW = 20,
    parameter int KP = 0,
    parameter int KI = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clr,
    input  logic                 upd,
    input  logic signed [IW-1:0] err,
    input  logic [TW-1:0]        nominal,
    output logic [TW-1:0]        word
);
    localparam int AW = IW + 16;
    localparam logic signed [AW-1:0] KI_W  = AW'(KI);
    localparam logic signed [AW-1:0] KP_W  = AW'(KP);
    localparam logic signed [AW-1:0] MAX_W = AW'((64'd1 << TW) - 64'd1);

    logic signed [IW-1:0] integ;
    logic signed [IW-1:0] integ_nx;
    logic signed [AW-1:0] integ_x;
    logic signed [AW-1:0] err_x;
    logic signed [AW-1:0] nom_x;
    logic signed [AW-1:0] sum;
    logic [TW-1:0]        word_nx;

    // Next integral and unclamped word in a wide signed domain
    always_comb begin
        integ_nx = integ + err;
        integ_x  = {{(AW-IW){integ_nx[IW-1]}}, integ_nx};
        err_x    = {{(AW-IW){err[IW-1]}}, err};
        nom_x    = {{(AW-TW){1'b0}}, nominal};
        sum      = nom_x + KI_W * integ_x + KP_W * err_x;
    end

    // Clamp into the unsigned word range
    always_comb begin
        if (sum < 0)
            word_nx = '0;
        else if (sum > MAX_W)
            word_nx = MAX_W[TW-1:0];
        else
            word_nx = sum[TW-1:0];
    end

    // Integral and word registers; clear beats update
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            integ <= '0;
            word  <= nominal;
        end else if (clr) begin
            integ <= '0;
            word  <= nominal;
        end else if (upd) begin
            integ <= integ_nx;
            word  <= word_nx;
        end
    end

    // R7
    clr_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (integ == '0) && (word == $past(nominal)));

    // R5
    integ_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !upd) |=> $stable(integ) && $stable(word));

    // R5
    integ_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (upd && !clr) |=> integ == $past(integ) + $past(err));
endmodule

// File: rtl/clk_err_pi_top.sv
// Module: master-clock frequency error PI controller, top level.
// Tracks the selected rate, arms on the first check point after reset or a
// rate change, and issues a tuning word with a strobe for each later one.
// Assumes cnt_valid is a one-cycle strobe per check point.
module clk_err_pi_top
    import clk_err_pi_pkg::*;
#(
    parameter int KP = 0,
    parameter int KI = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rate_sel,
    input  logic [CNT_W-1:0]  cnt_now,
    input  logic [CNT_W-1:0]  cnt_prev,
    input  logic              cnt_valid,
    output logic [WORD_W-1:0] tune_word,
    output logic              tune_valid
);
    rate_cfg_t                cfg;
    logic                     rate_q;
    logic                     rate_chg;
    logic                     armed;
    logic                     upd;
    logic signed [INT_W-1:0]  err;

    clk_err_rate_table u_table (
        .rate_sel (rate_sel),
        .cfg      (cfg)
    );

    clk_err_phase_det #(.CW(CNT_W), .EW(INT_W)) u_det (
        .cnt_now  (cnt_now),
        .cnt_prev (cnt_prev),
        .exp_adv  (cfg.exp_adv),
        .err      (err)
    );

    // A rate differing from the one last seen is a change
    always_comb begin
        rate_chg = (rate_sel != rate_q);
        upd      = cnt_valid && armed && !rate_chg;
    end

    // Remember the rate; the reset value matches the 44.1 kHz family
    always_ff @(posedge clk) begin
        if (!rst_n) rate_q <= 1'b0;
        else        rate_q <= rate_sel;
    end

    // Arm on the first check point, disarm on a rate change
    always_ff @(posedge clk) begin
        if (!rst_n)         armed <= 1'b0;
        else if (rate_chg)  armed <= 1'b0;
        else if (cnt_valid) armed <= 1'b1;
    end

    // Output strobe follows each accepted check point
    always_ff @(posedge clk) begin
        if (!rst_n) tune_valid <= 1'b0;
        else        tune_valid <= upd;
    end

    clk_err_pi_core #(.IW(INT_W), .TW(WORD_W), .KP(KP), .KI(KI)) u_core (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (rate_chg),
        .upd     (upd),
        .err     (err),
        .nominal (cfg.nominal),
        .word    (tune_word)
    );

    // R8
    strobe_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tune_valid |-> $past(cnt_valid) && !$past(rate_chg));

    // R2
    first_sample_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_valid && !armed) |=> !tune_valid && $stable(tune_word));

    // R7
    rate_chg_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rate_chg |=> !tune_valid);
endmodule

// File: tb/clk_err_pi_top_bench.sv
// Bench: random and directed check points against a reference model.
module clk_err_pi_top_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rate_sel = 1'b0;
    logic [15:0] cnt_now = '0;
    logic [15:0] cnt_prev = '0;
    logic        cnt_valid = 1'b0;
    logic [19:0] tune_word;
    logic        tune_valid;

    int n_tests = 0;
    int n_fail  = 0;
    int m_integ = 0;
    int m_word  = 0;
    bit m_armed = 0;
    bit done    = 0;

    always #4 clk = ~clk;

    clk_err_pi_top u_clk_err_pi_top (
        .clk(clk), .rst_n(rst_n), .rate_sel(rate_sel),
        .cnt_now(cnt_now), .cnt_prev(cnt_prev), .cnt_valid(cnt_valid),
        .tune_word(tune_word), .tune_valid(tune_valid)
    );

    function automatic int exp_of(bit r);   // R9
        return r ? 49152 : 29184;
    endfunction

    function automatic int nom_of(bit r);   // R9
        return r ? 478151 : 498283;
    endfunction

    function automatic int err_of(logic [15:0] nw, logic [15:0] pv, bit r);
        logic [15:0] adv;
        logic [15:0] d;
        adv = nw - pv;
        d   = 16'(exp_of(r)) - adv;
        return int'($signed(d));
    endfunction

    function automatic int sat_of(longint s);
        if (s < 0) return 0;
        if (s > 1048575) return 1048575;
        return int'(s);
    endfunction

    task automatic check(string req, int act, int expv);
        n_tests++;
        if (act != expv) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    // Present one check point for one cycle; check the result after the edge
    task automatic sample(logic [15:0] pv, int adv, string req);
        int e;
        cnt_prev  = pv;
        cnt_now   = pv + 16'(adv);
        cnt_valid = 1'b1;
        @(negedge clk);
        cnt_valid = 1'b0;
        if (!m_armed) begin
            m_armed = 1;
            check({req, " first sample strobe (R2)"}, int'(tune_valid), 0);
            check({req, " first sample word (R2)"}, int'(tune_word), m_word);
        end else begin
            e = err_of(cnt_prev, cnt_now - 16'(0) , rate_sel);
            e = err_of(cnt_now, cnt_prev, rate_sel);
            m_integ += e;
            m_word = sat_of(longint'(nom_of(rate_sel)) + 64'sd32 * longint'(m_integ));
            check({req, " strobe (R8)"}, int'(tune_valid), 1);
            check({req, " word (R5)"}, int'(tune_word), m_word);
            @(negedge clk);
            check({req, " strobe drops (R8)"}, int'(tune_valid), 0);
        end
    endtask

    task automatic change_rate(bit r);
        rate_sel = r;
        @(negedge clk);
        m_integ = 0;
        m_armed = 0;
        m_word  = nom_of(r);
        check("R7 reload nominal", int'(tune_word), m_word);
        check("R7 no strobe", int'(tune_valid), 0);
    endtask

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        m_word = nom_of(0);
        check("R1 reset word", int'(tune_word), 498283);
        check("R1 reset strobe", int'(tune_valid), 0);

        sample(16'd100, 29184, "R2 arm");
        sample(16'd200, 29184, "R9 exact rate0");
        sample(16'd65000, 29184 + 10, "R3 wrap");
        check("R4 fast lowers word", int'(tune_word < 20'd498283), 1);
        sample(16'd5, 29184 - 10, "R4 slow");
        check("R4 back to nominal", int'(tune_word), 498283);

        // R6 upper clamp: slow clock by 20000 twice
        sample(16'd0, 29184 - 20000, "R6 up1");
        sample(16'd0, 29184 - 20000, "R6 up2");
        check("R6 clamp high", int'(tune_word), 1048575);
        // R6 lower clamp
        sample(16'd0, 29184 + 30000, "R6 dn1");
        sample(16'd0, 29184 + 30000, "R6 dn2");
        check("R6 clamp low", int'(tune_word), 0);

        // R7 rate change with a coincident strobe that must be ignored
        rate_sel  = 1'b1;
        cnt_prev  = 16'd0;
        cnt_now   = 16'd1000;
        cnt_valid = 1'b1;
        @(negedge clk);
        cnt_valid = 1'b0;
        m_integ = 0; m_armed = 0; m_word = nom_of(1);
        check("R7 coincident ignored strobe", int'(tune_valid), 0);
        check("R7 coincident reload", int'(tune_word), 478151);
        sample(16'd300, 49152, "R7 rearm");
        sample(16'd300, 49152, "R9 exact rate1");
        check("R9 rate1 nominal", int'(tune_word), 478151);
        change_rate(0);

        // Random traffic with occasional rate changes and idle gaps
        for (int i = 0; i < 300; i++) begin
            int dev;
            logic [15:0] pv;
            if (($urandom % 40) == 0) change_rate(~rate_sel);
            dev = int'($urandom % 601) - 300;
            pv  = 16'($urandom);
            sample(pv, exp_of(rate_sel) + dev, "R5 random");
            repeat ($urandom % 3) begin
                @(negedge clk);
                check("R8 idle no strobe", int'(tune_valid), 0);
            end
        end

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule